// File: doc/BRIEF.md
# Buffered Up/Down PWM Timer Channel

This block is one channel of a general-purpose PWM timer. A 32-bit counter advances on ticks from a prescaler whose ratio is a power of four, from 1 to 1024. The counter runs as a rising sawtooth, a falling sawtooth, or a triangle that climbs to the period value and falls back to zero. Two compare values, one per output pin, set the duty of two PWM outputs. Each output is high while the count is below its compare value, and a polarity bit can invert it. Overflow and underflow pulses mark the top and bottom turning points.

Software reaches the block through a small write-only register port. The compare values and the period are buffered. New values wait in shadow registers and move to the active registers at a transfer point, so a running waveform never sees a half-updated frame. In triangle mode the transfer can be taken at the crest, at the trough, or at both. Taking it at only one of them lets the rising and falling halves use different compare values, which gives laterally asymmetric PWM. While the channel is stopped, writes load the active registers at once, so a fresh configuration is in force from the first tick.

Top module: `pwm_timer_channel`

## Requirements
- R1: After reset the count is 0, the direction is up, both PWM outputs and both interrupt pulses are low, and the channel is stopped.
- R2: The count advances once every 4^N clock cycles, where N is the prescale field in control bits [5:3]. The values 6 and 7 act as 5.
- R3: With control bits [2:1] = 0 (or 3), the count climbs from 0 to the period, and on the next tick it reloads 0. The overflow output is high for exactly the cycle in which the reloaded 0 is shown.
- R4: With control bits [2:1] = 1, the count falls from the period to 0, and on the next tick it reloads the period. The underflow output is high for exactly the cycle in which the reloaded period is shown.
- R5: With control bits [2:1] = 2, the count rises by one per tick until it reaches the period, then turns and falls by one per tick until it reaches 0, then turns again. Overflow pulses with the first value after the crest, and underflow pulses with the first value after the trough. count_down_o shows the falling half.
- R6: With buffering on (control bit 8 = 1) and the channel running, a compare write in sawtooth mode has no effect on the outputs until the next reload point.
- R7: In triangle mode, control bits [7:6] choose when the buffers are copied to the active registers: 01 at the crest only, 10 at the trough only, 11 at both, 00 never.
- R8: With buffering off (control bit 8 = 0), a compare write takes effect on the output in the cycle right after the write.
- R9: A period write made while running is applied only at the next transfer point. A period write made while stopped is applied at once.
- R10: Output A (compare at address 2) and output B (compare at address 3) are high when count < compare. Control bits 9 and 10 invert A and B respectively.
- R11: With control bit 0 (run) clear, the count and both outputs hold their values. Compare writes made while stopped go straight to the active registers.
- R12: Any write to address 4 sets the count to 0, the direction to up, and the prescaler phase to zero, even in a cycle that would otherwise tick. It raises no interrupt pulse.
- R13: If a buffer write coincides with a transfer point, the active register takes the previous buffer contents, and the newly written value waits for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 period, 2 compare A, 3 compare B, 4 clear |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Present counter value |
| count_down_o | output | 1 | High while the counter is falling |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |
| ovf_irq_o | output | 1 | One-cycle overflow pulse |
| udf_irq_o | output | 1 | One-cycle underflow pulse |

## Verification
Two collisions get the most attention. The first is a buffered compare write landing in the very cycle of a reload: the bench counts cycles to the edge on which the count leaves the period value and drives the write into that same edge. It then expects the old buffer contents on the output for one more whole frame. The second is a clear that arrives while the prescaler is ticking every cycle in the falling half of a triangle: the clear must win, with no pulse and with the direction forced up. A cycle-accurate arithmetic model in the bench judges both cases, along with sweeps over every mode, small periods, all compare values and both polarities.

// File: rtl/pwm_tmr_pkg.sv
// Shared definitions for the PWM timer channel: counting modes,
// register addresses and the prescaler limit function.
package pwm_tmr_pkg;

    typedef enum logic [1:0] {
        CM_UP   = 2'd0,
        CM_DOWN = 2'd1,
        CM_TRI  = 2'd2
    } cnt_mode_e;

    localparam int PS_MAX = 5;
    localparam int PRE_W  = 2 * PS_MAX;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_PER  = 3'd1;
    localparam logic [2:0] ADDR_CMPA = 3'd2;
    localparam logic [2:0] ADDR_CLR  = 3'd4;

    // Last prescaler phase before a tick for a 3-bit ratio field (4^N - 1).
    function automatic logic [PRE_W-1:0] ps_limit(input logic [2:0] ps);
        logic [2:0] p;
        int         v;
        p = (ps > 3'(PS_MAX)) ? 3'(PS_MAX) : ps;
        v = (1 << (2 * int'(p))) - 1;
        return v[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/pwm_tmr_prescaler.sv
// Power-of-four clock divider. Issues a single-cycle tick every 4^N
// cycles while run is high. Assumes the ratio field is registered
// upstream; a ratio lowered mid-phase ticks at once (>= compare).
module pwm_tmr_prescaler
    import pwm_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [2:0] ps,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    // Decode the ratio field into the terminal phase.
    always_comb lim = ps_limit(ps);

    assign tick = run && (pre_q >= lim);

    // Advance the phase counter; restart on tick or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          pre_q <= '0;
        else if (clr || tick) pre_q <= '0;
        else if (run)        pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
    end

    // R2: every tick restarts the phase from zero.
    p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0));

    // R11: a stopped prescaler keeps its phase.
    p_phase_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pre_q));

endmodule

// File: rtl/pwm_tmr_counter.sv
// Up / down / triangle counter core. Steps on each prescaler tick,
// reports turning points as registered interrupt pulses and flags the
// buffer transfer point combinationally for the edge it occurs on.
// Assumes clr has priority over tick and the period input is stable
// except at transfer points.
module pwm_tmr_counter
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  cnt_mode_e        mode,
    input  logic [1:0]       xsel,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dir_dn_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             ovf_q,
    output logic             udf_q,
    output logic             xfer
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic dir_d, ovf_d, udf_d;

    // Next-state of count, direction, pulses and transfer strobe.
    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_dn_q;
        ovf_d = 1'b0;
        udf_d = 1'b0;
        xfer  = 1'b0;
        if (clr) begin
            cnt_d = ZERO;
            dir_d = 1'b0;
        end else if (tick) begin
            case (mode)
                CM_UP: begin
                    dir_d = 1'b0;
                    if (cnt_q >= per) begin
                        cnt_d = ZERO;
                        ovf_d = 1'b1;
                        xfer  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                CM_DOWN: begin
                    dir_d = 1'b1;
                    if (cnt_q == ZERO) begin
                        cnt_d = per;
                        udf_d = 1'b1;
                        xfer  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                CM_TRI: begin
                    if (!dir_dn_q) begin
                        if (cnt_q >= per) begin
                            dir_d = 1'b1;
                            cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
                            ovf_d = 1'b1;
                            xfer  = xsel[0];
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end else begin
                        if (cnt_q == ZERO) begin
                            dir_d = 1'b0;
                            cnt_d = (per == ZERO) ? ZERO : ONE;
                            udf_d = 1'b1;
                            xfer  = xsel[1];
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: begin
                    cnt_d = cnt_q;
                end
            endcase
        end
    end

    // Register count, direction and the interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= ZERO;
            dir_dn_q <= 1'b0;
            ovf_q    <= 1'b0;
            udf_q    <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            dir_dn_q <= dir_d;
            ovf_q    <= ovf_d;
            udf_q    <= udf_d;
        end
    end

    // R3: an up-count at or past the period reloads zero with overflow.
    p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && mode == CM_UP && cnt_q >= per) |=> (cnt_q == ZERO && ovf_q));

    // R4: a down-count at zero reloads the period with underflow.
    p_down_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && mode == CM_DOWN && cnt_q == ZERO) |=> (cnt_q == $past(per) && udf_q));

    // R5: the two turning-point pulses never coincide.
    p_irq_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_q && udf_q));

    // R12: clear yields zero, upward direction and no pulse.
    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == ZERO && !dir_dn_q && !ovf_q && !udf_q));

    // R11: without a tick or clear the count holds.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_tmr_compare.sv
// One compare channel: shadow buffer, active compare register and the
// registered PWM output. Output is (count < compare) ^ polarity, built
// from next-state values so it lines up with the shown count. Assumes
// xfer only occurs while run is high.
module pwm_tmr_compare #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             buf_en,
    input  logic             run,
    input  logic             xfer,
    input  logic             pol,
    input  logic [CNT_W-1:0] cnt_d,
    output logic             pwm_q
);

    logic [CNT_W-1:0] buf_q, act_q, act_d;

    // Select the active compare value for the coming cycle.
    always_comb begin
        act_d = act_q;
        if (xfer && buf_en)        act_d = buf_q;
        if (wr && (!buf_en || !run)) act_d = wdata;
    end

    // Register buffer, active value and the output pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            if (wr) buf_q <= wdata;
            act_q <= act_d;
            if (run) pwm_q <= (cnt_d < act_d) ^ pol;
        end
    end

    // R8: unbuffered writes land in the active register next cycle.
    p_direct_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !buf_en) |=> (act_q == $past(wdata)));

    // R6: a running buffered channel changes compare only at transfer.
    p_buffer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && run && !xfer && !wr) |=> $stable(act_q));

    // R11: a stopped channel holds its output.
    p_pwm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pwm_q));

endmodule

// File: rtl/pwm_timer_channel.sv
// Top of one PWM timer channel: write-port register decode, buffered
// period, prescaler, counter core and two compare units. Assumes
// CNT_W >= 11 so the control fields fit in one data word.
module pwm_timer_channel
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             count_down_o,
    output logic             pwm_a_o,
    output logic             pwm_b_o,
    output logic             ovf_irq_o,
    output logic             udf_irq_o
);

    logic             run_q, buf_en_q;
    cnt_mode_e        mode_q;
    logic [2:0]       ps_q;
    logic [1:0]       xsel_q;
    logic [N_OUT-1:0] pol_q;
    logic [CNT_W-1:0] per_buf_q, per_act_q;
    logic [CNT_W-1:0] cnt_d;
    logic [N_OUT-1:0] pwm_vec;
    logic             tick, clr, xfer, wr_ctrl, wr_per;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_per  = wr_en && (wr_addr == ADDR_PER);
    assign clr     = wr_en && (wr_addr == ADDR_CLR);

    // Capture control fields; mode code 3 folds onto rising sawtooth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            mode_q   <= CM_UP;
            ps_q     <= 3'd0;
            xsel_q   <= 2'b00;
            buf_en_q <= 1'b0;
            pol_q    <= '0;
        end else if (wr_ctrl) begin
            run_q    <= wr_data[0];
            mode_q   <= cnt_mode_e'((wr_data[2:1] == 2'd3) ? 2'd0 : wr_data[2:1]);
            ps_q     <= wr_data[5:3];
            xsel_q   <= wr_data[7:6];
            buf_en_q <= wr_data[8];
            pol_q    <= wr_data[9 +: N_OUT];
        end
    end

    // Period shadow and active copy: direct when stopped, else at transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_buf_q <= '0;
            per_act_q <= '0;
        end else begin
            if (wr_per) per_buf_q <= wr_data;
            if (wr_per && !run_q) per_act_q <= wr_data;
            else if (xfer)        per_act_q <= per_buf_q;
        end
    end

    pwm_tmr_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .clr   (clr),
        .ps    (ps_q),
        .tick  (tick)
    );

    pwm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (clr),
        .mode     (mode_q),
        .xsel     (xsel_q),
        .per      (per_act_q),
        .cnt_q    (count_o),
        .dir_dn_q (count_down_o),
        .cnt_d    (cnt_d),
        .ovf_q    (ovf_irq_o),
        .udf_q    (udf_irq_o),
        .xfer     (xfer)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_cmp
        pwm_tmr_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_en && (wr_addr == (ADDR_CMPA + 3'(g)))),
            .wdata  (wr_data),
            .buf_en (buf_en_q),
            .run    (run_q),
            .xfer   (xfer),
            .pol    (pol_q[g]),
            .cnt_d  (cnt_d),
            .pwm_q  (pwm_vec[g])
        );
    end

    assign pwm_a_o = pwm_vec[0];
    assign pwm_b_o = pwm_vec[N_OUT-1];

    // R9: a running period write waits for a transfer point.
    p_period_buffered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !xfer) |=> $stable(per_act_q));

    // R1: nothing moves or pulses before the channel is first started.
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !tick);

endmodule

// File: tb/test_pwm_timer_channel.sv
// Self-checking bench: a cycle-level arithmetic model runs in lockstep
// with the channel and every output is compared each cycle.
module test_pwm_timer_channel;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = 3'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count_o;
    logic         count_down_o, pwm_a_o, pwm_b_o, ovf_irq_o, udf_irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timer_channel #(.CNT_W(W)) i_pwm_timer_channel (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .count_o      (count_o),
        .count_down_o (count_down_o),
        .pwm_a_o      (pwm_a_o),
        .pwm_b_o      (pwm_b_o),
        .ovf_irq_o    (ovf_irq_o),
        .udf_irq_o    (udf_irq_o)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R1";

    // ---------------- reference model ----------------
    logic         m_run, m_bufen, m_dn, m_ovf, m_udf;
    logic [1:0]   m_mode, m_sel, m_pol, m_pwm;
    logic [2:0]   m_ps;
    logic [W-1:0] m_perb, m_pera, m_cnt;
    logic [W-1:0] m_cb [2];
    logic [W-1:0] m_ca [2];
    int           m_pre;

    always @(posedge clk) begin
        int           lim, pe;
        logic         clr, tk, xf, n_dn, n_ovf, n_udf;
        logic [W-1:0] n_cnt, n_pera;
        logic [W-1:0] n_ca [2];
        if (!rst_n) begin
            m_run = 0; m_bufen = 0; m_dn = 0; m_ovf = 0; m_udf = 0;
            m_mode = 0; m_sel = 0; m_pol = 0; m_pwm = 0; m_ps = 0;
            m_perb = 0; m_pera = 0; m_cnt = 0; m_pre = 0;
            m_cb[0] = 0; m_cb[1] = 0; m_ca[0] = 0; m_ca[1] = 0;
        end else begin
            pe = (m_ps > 5) ? 5 : int'(m_ps);
            lim = 1;
            for (int k = 0; k < pe; k++) lim = lim * 4;
            lim = lim - 1;
            clr = wr_en && wr_addr == 3'd4;
            tk  = m_run && (m_pre >= lim);
            n_cnt = m_cnt; n_dn = m_dn; n_ovf = 0; n_udf = 0; xf = 0;
            if (clr) begin
                n_cnt = 0; n_dn = 0;
            end else if (tk) begin
                if (m_mode == 2'd1) begin
                    n_dn = 1;
                    if (m_cnt == 0) begin n_cnt = m_pera; n_udf = 1; xf = 1; end
                    else n_cnt = m_cnt - 1;
                end else if (m_mode == 2'd2) begin
                    if (!m_dn) begin
                        if (m_cnt >= m_pera) begin
                            n_dn = 1; n_ovf = 1; xf = m_sel[0];
                            n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
                        end else n_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin
                            n_dn = 0; n_udf = 1; xf = m_sel[1];
                            n_cnt = (m_pera == 0) ? 0 : 1;
                        end else n_cnt = m_cnt - 1;
                    end
                end else begin
                    n_dn = 0;
                    if (m_cnt >= m_pera) begin n_cnt = 0; n_ovf = 1; xf = 1; end
                    else n_cnt = m_cnt + 1;
                end
            end
            m_pre = (clr || tk) ? 0 : (m_run ? m_pre + 1 : m_pre);
            n_pera = m_pera;
            if (wr_en && wr_addr == 3'd1 && !m_run) n_pera = wr_data;
            else if (xf) n_pera = m_perb;
            if (wr_en && wr_addr == 3'd1) m_perb = wr_data;
            for (int i = 0; i < 2; i++) begin
                n_ca[i] = m_ca[i];
                if (xf && m_bufen) n_ca[i] = m_cb[i];
                if (wr_en && wr_addr == 3'(2 + i) && (!m_bufen || !m_run)) n_ca[i] = wr_data;
                if (wr_en && wr_addr == 3'(2 + i)) m_cb[i] = wr_data;
                if (m_run) m_pwm[i] = (n_cnt < n_ca[i]) ^ m_pol[i];
                m_ca[i] = n_ca[i];
            end
            m_cnt = n_cnt; m_dn = n_dn; m_ovf = n_ovf; m_udf = n_udf; m_pera = n_pera;
            if (wr_en && wr_addr == 3'd0) begin
                m_run = wr_data[0];
                m_mode = (wr_data[2:1] == 2'd3) ? 2'd0 : wr_data[2:1];
                m_ps = wr_data[5:3]; m_sel = wr_data[7:6];
                m_bufen = wr_data[8]; m_pol = wr_data[10:9];
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("count", count_o, m_cnt);
        chk("direction", W'(count_down_o), W'(m_dn));
        chk("pwm_a", W'(pwm_a_o), W'(m_pwm[0]));
        chk("pwm_b", W'(pwm_b_o), W'(m_pwm[1]));
        chk("overflow", W'(ovf_irq_o), W'(m_ovf));
        chk("underflow", W'(udf_irq_o), W'(m_udf));
    endtask

    // One cycle: check at the falling edge, then drive the next edge's inputs.
    task automatic cyc(input logic we, input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        check_all();
        wr_en = we; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b0, 3'd0, '0);
    endtask

    function automatic logic [W-1:0] ctrl(input logic run, input logic [1:0] mode,
        input logic [2:0] ps, input logic [1:0] sel, input logic bufen, input logic [1:0] pol);
        return W'({pol, bufen, sel, ps, mode, run});
    endfunction

    // Stop, clear, load period and compares directly, then start.
    task automatic setup(input logic [1:0] mode, input int per, input int ca, input int cb,
        input logic bufen, input logic [1:0] sel, input logic [1:0] pol, input logic [2:0] ps);
        cyc(1, 3'd0, ctrl(0, mode, ps, sel, bufen, pol));
        cyc(1, 3'd4, '0);
        cyc(1, 3'd1, W'(per));
        cyc(1, 3'd2, W'(ca));
        cyc(1, 3'd3, W'(cb));
        cyc(1, 3'd0, ctrl(1, mode, ps, sel, bufen, pol));
    endtask

    task automatic wait_count(input int v);
        int guard = 0;
        while (count_o != W'(v) && guard < 5000) begin idle(1); guard++; end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(posedge clk);
        tag = "R1";
        @(negedge clk);
        check_all();
        rst_n = 1'b1;
        idle(4);

        // Sweep modes, periods, compares and polarities.
        for (int mode = 0; mode < 3; mode++) begin
            for (int per = 0; per < 6; per++) begin
                for (int ca = 0; ca <= per + 1; ca++) begin
                    for (int pol = 0; pol < 2; pol++) begin
                        tag = (mode == 0) ? "R3" : (mode == 1) ? "R4" : "R5";
                        setup(2'(mode), per, ca, per + 1 - ca, 1'b1, 2'b11,
                              pol ? 2'b01 : 2'b10, 3'd0);
                        idle(2 * per + 5);
                    end
                end
            end
        end

        // Mode code 3 acts as rising sawtooth.
        tag = "R3";
        setup(2'd3, 4, 2, 3, 1'b0, 2'b00, 2'b00, 3'd0);
        idle(12);

        // Prescaler ratio: measure cycles between two count steps.
        for (int ps = 0; ps < 8; ps++) begin
            int n, prev, expn;
            tag = "R2";
            setup(2'd0, 3, 1, 2, 1'b0, 2'b00, 2'b00, 3'(ps));
            prev = int'(count_o);
            while (int'(count_o) == prev) idle(1);
            prev = int'(count_o);
            n = 0;
            while (int'(count_o) == prev && n < 3000) begin idle(1); n++; end
            expn = 1;
            for (int k = 0; k < ((ps > 5) ? 5 : ps); k++) expn = expn * 4;
            chk("step interval R2", W'(n), W'(expn));
        end

        // Buffered sawtooth compare write mid-frame.
        tag = "R6";
        setup(2'd0, 7, 3, 5, 1'b1, 2'b00, 2'b00, 3'd0);
        wait_count(1);
        cyc(1, 3'd2, W'(6));
        cyc(1, 3'd3, W'(1));
        idle(20);

        // Triangle transfer selection: none, crest, trough, both.
        for (int sel = 0; sel < 4; sel++) begin
            tag = "R7";
            setup(2'd2, 6, 2, 4, 1'b1, 2'(sel), 2'b00, 3'd0);
            wait_count(2);
            cyc(1, 3'd2, W'(5));
            idle(3);
            cyc(1, 3'd3, W'(1));
            idle(30);
        end

        // Unbuffered compare writes while running.
        tag = "R8";
        setup(2'd0, 9, 2, 7, 1'b0, 2'b00, 2'b00, 3'd0);
        wait_count(3);
        cyc(1, 3'd2, W'(8));
        idle(2);
        cyc(1, 3'd3, W'(0));
        idle(12);

        // Period change while running, then while stopped.
        tag = "R9";
        setup(2'd0, 6, 3, 3, 1'b1, 2'b00, 2'b00, 3'd0);
        wait_count(1);
        cyc(1, 3'd1, W'(2));
        idle(16);
        setup(2'd1, 5, 2, 4, 1'b1, 2'b00, 2'b00, 3'd0);
        wait_count(4);
        cyc(1, 3'd1, W'(8));
        idle(24);

        // Both polarities inverted in triangle mode.
        tag = "R10";
        setup(2'd2, 5, 1, 4, 1'b0, 2'b11, 2'b11, 3'd1);
        idle(60);

        // Stop mid-frame, write compares while stopped, then restart.
        tag = "R11";
        setup(2'd2, 8, 3, 6, 1'b1, 2'b11, 2'b00, 3'd0);
        wait_count(5);
        cyc(1, 3'd0, ctrl(0, 2'd2, 3'd0, 2'b11, 1'b1, 2'b00));
        idle(3);
        cyc(1, 3'd2, W'(7));
        cyc(1, 3'd3, W'(0));
        idle(3);
        cyc(1, 3'd0, ctrl(1, 2'd2, 3'd0, 2'b11, 1'b1, 2'b00));
        idle(20);

        // Clear during the falling half of a triangle, ticking each cycle.
        tag = "R12";
        setup(2'd2, 6, 3, 2, 1'b1, 2'b11, 2'b00, 3'd0);
        wait_count(6);
        idle(2);
        cyc(1, 3'd4, '0);
        idle(1);
        chk("direction after clear R12", W'(count_down_o), '0);
        idle(16);
        setup(2'd0, 5, 2, 3, 1'b0, 2'b00, 2'b00, 3'd2);
        idle(40);
        cyc(1, 3'd4, '0);
        idle(40);

        // Buffer write landing exactly on the reload edge.
        tag = "R13";
        setup(2'd0, 3, 1, 2, 1'b1, 2'b00, 2'b00, 3'd0);
        cyc(1, 3'd2, W'(3));
        wait_count(2);
        cyc(1, 3'd2, W'(0));
        idle(12);

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule